// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts processor activity for profiling. It has one free-running cycle counter and two event counters, all 32 bits wide. Each event counter picks one line from a vector of event pulses using an 8-bit code. Every setting sits in one combined control word: the run bit, the counter clears, a divide-by-64 option for the cycle counter, one interrupt enable per counter, one sticky wrap flag per counter and both event codes.

Software reaches the block through a small register port with four data indices. Index 0 is the control word, index 1 the cycle counter, index 2 event counter 0 and index 3 event counter 1. A counter register can be preloaded, for example with a value just below wrap, so that the interrupt fires after a chosen number of events. The interrupt output is a level. It stays high while any wrap flag is set and its enable is on, and software clears it by writing the flag back as 1.

Top module: `pmu_two_counter`

## Requirements
- R1: After reset, all four data indices read 0 and irq is 0.
- R2: In the control word, bit 0 is run, bit 3 is divide-by-64, bits 6:4 are the interrupt enables, bits 19:12 are the event-0 code and bits 27:20 are the event-1 code; these read back as written. Bits 1 and 2 read 0. Bits 7, 11 and 31:28 are forced to 0 on write.
- R3: The wrap flags sit at bit 8 (event 0), bit 9 (event 1) and bit 10 (cycle). A counter sets its flag when it steps from 0xFFFFFFFF to 0. A control write with a flag bit at 1 clears that flag. A 0 in that bit leaves the flag unchanged.
- R4: If a wrap and a clearing write hit the same flag in the same cycle, the flag ends set.
- R5: An event counter adds one in every cycle where run is 1 and the event input named by its code is 1.
- R6: An event counter whose code is 0xFF never advances, whatever the event inputs do.
- R7: While run is 0, no counter changes except through a register write or a clear.
- R8: The cycle counter adds one in every cycle where run is 1. With bit 3 set, it adds one only on every 64th such cycle, counted from its last clear.
- R9: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to bit 2 zeroes the cycle counter and its divide-by-64 phase. Neither write touches the other counters.
- R10: A write to index 1, 2 or 3 loads that counter, and this load takes priority over an increment in the same cycle. A read returns the current value.
- R11: irq is 1 exactly when some wrap flag is set and its enable is set. The cycle enable is bit 6, the event-0 enable is bit 4 and the event-1 enable is bit 5.
- R12: A control write takes effect for counting from the cycle after the write. The write cycle itself counts under the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Data index: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| event_in | input | NUM_EVT | Event pulses, one per event code |
| irq | output | 1 | Level interrupt |

## Verification
The counting assertions only judge cycles with no register write. They treat event_in as a level sampled at each clock edge, so a pulse is simply a line that is high for one cycle. The bench drives every input at the falling edge and holds writes to one cycle each. It places collisions, such as a wrap that meets a clearing write or a load that meets an increment, on a known rising edge. The event sweep tries every code on event counter 0, including the unused code. Each pass drives a fixed pattern: the chosen line, a second line for event counter 1, and one line that should be ignored.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 8;
  localparam int NUM_CNT = 3;
  // counter slots, ordered as the flag and enable bits
  localparam int IX_EV0 = 0;
  localparam int IX_EV1 = 1;
  localparam int IX_CYC = 2;

  localparam int B_RUN   = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;
  localparam int B_IE    = 4;
  localparam int B_FLAG  = 8;
  localparam int B_SEL0  = 12;
  localparam int B_SEL1  = 20;

  localparam logic [SEL_W-1:0] CODE_IDLE = 8'hFF;
  localparam logic [REG_W-1:0] WR_KEEP   = 32'h0FFF_F77F;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_addr_e;

  function automatic logic [1:0] slot_addr(input int slot);
    case (slot)
      IX_EV0:  return RA_EV0;
      IX_EV1:  return RA_EV1;
      default: return RA_CYC;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] filter_write(input logic [REG_W-1:0] w);
    return w & WR_KEEP;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(
      input logic run, input logic div, input logic [NUM_CNT-1:0] ie,
      input logic [NUM_CNT-1:0] flag, input logic [SEL_W-1:0] s0,
      input logic [SEL_W-1:0] s1);
    return {4'b0, s1, s0, 1'b0, flag, 1'b0, ie, div, 2'b00, run};
  endfunction
endpackage

// File: rtl/pmu_count_reg.sv
`timescale 1ns/1ps
module pmu_count_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_top;
  assign at_top = &cnt;
  assign wrap   = inc & ~clr & ~ld & at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pmu_prescale.sv
`timescale 1ns/1ps
module pmu_prescale #(
  parameter int LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [LOG2-1:0] phase;
  assign tick = run & (&phase);

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else if (run) phase <= phase + LOG2'(1);
  end
endmodule

// File: rtl/pmu_evt_pick.sv
`timescale 1ns/1ps
module pmu_evt_pick #(
  parameter int NUM_EVT = 256
) (
  input  logic [NUM_EVT-1:0] event_in,
  input  logic [7:0]         sel,
  output logic               hit
);
  localparam int SPAN = 256;
  logic [SPAN-1:0] padded;

  for (genvar i = 0; i < SPAN; i++) begin : g_pad
    if (i < NUM_EVT) begin : g_live
      assign padded[i] = event_in[i];
    end else begin : g_dead
      assign padded[i] = 1'b0;
    end
  end

  assign hit = (sel != pmu_pkg::CODE_IDLE) & padded[sel];
endmodule

// File: rtl/pmu_ctrl_reg.sv
`timescale 1ns/1ps
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_CNT-1:0] wrap,
  output logic               run,
  output logic               div,
  output logic [NUM_CNT-1:0] ie,
  output logic [NUM_CNT-1:0] flag,
  output logic [SEL_W-1:0]   sel0,
  output logic [SEL_W-1:0]   sel1,
  output logic               ev_clr,
  output logic               cyc_clr,
  output logic [REG_W-1:0]   word
);
  logic [REG_W-1:0]   wf;
  logic [NUM_CNT-1:0] clr_req;

  assign wf      = filter_write(wdata);
  assign clr_req = wr ? wf[B_FLAG +: NUM_CNT] : '0;
  assign ev_clr  = wr & wf[B_EVCLR];
  assign cyc_clr = wr & wf[B_CYCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      div  <= 1'b0;
      ie   <= '0;
      sel0 <= '0;
      sel1 <= '0;
      flag <= '0;
    end else begin
      if (wr) begin
        run  <= wf[B_RUN];
        div  <= wf[B_DIV];
        ie   <= wf[B_IE +: NUM_CNT];
        sel0 <= wf[B_SEL0 +: SEL_W];
        sel1 <= wf[B_SEL1 +: SEL_W];
      end
      // a new wrap outranks a clearing write
      flag <= (flag & ~clr_req) | wrap;
    end
  end

  assign word = pack_ctrl(run, div, ie, flag, sel0, sel1);
endmodule

// File: rtl/pmu_two_counter.sv
`timescale 1ns/1ps
module pmu_two_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVT       = 256,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] event_in,
  output logic               irq
);
  logic               ctrl_run, ctrl_div, ev_clr, cyc_clr, cyc_tick, ctrl_wr;
  logic [NUM_CNT-1:0] ie_bits, ov_flags, wrap_vec, inc_vec, clr_vec, ld_vec;
  logic [SEL_W-1:0]   sel0, sel1;
  logic [REG_W-1:0]   ctrl_word;
  logic [1:0]         ev_hit;
  logic [REG_W-1:0]   cnt [NUM_CNT];
  logic [REG_W-1:0]   cnt_cyc, cnt_ev0, cnt_ev1;

  assign ctrl_wr = reg_we & (reg_addr == RA_CTRL);

  pmu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata), .wrap(wrap_vec),
    .run(ctrl_run), .div(ctrl_div), .ie(ie_bits), .flag(ov_flags),
    .sel0(sel0), .sel1(sel1), .ev_clr(ev_clr), .cyc_clr(cyc_clr), .word(ctrl_word)
  );

  pmu_prescale #(.LOG2(PRESCALE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .run(ctrl_run & ctrl_div), .tick(cyc_tick)
  );

  pmu_evt_pick #(.NUM_EVT(NUM_EVT)) u_pick0 (.event_in(event_in), .sel(sel0), .hit(ev_hit[0]));
  pmu_evt_pick #(.NUM_EVT(NUM_EVT)) u_pick1 (.event_in(event_in), .sel(sel1), .hit(ev_hit[1]));

  assign inc_vec[IX_EV0] = ctrl_run & ev_hit[0];
  assign inc_vec[IX_EV1] = ctrl_run & ev_hit[1];
  assign inc_vec[IX_CYC] = ctrl_run & (ctrl_div ? cyc_tick : 1'b1);
  assign clr_vec[IX_EV0] = ev_clr;
  assign clr_vec[IX_EV1] = ev_clr;
  assign clr_vec[IX_CYC] = cyc_clr;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign ld_vec[i] = reg_we & (reg_addr == slot_addr(i));
    pmu_count_reg #(.W(REG_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_vec[i]), .ld(ld_vec[i]), .ld_val(reg_wdata),
      .inc(inc_vec[i]), .cnt(cnt[i]), .wrap(wrap_vec[i])
    );
  end

  assign cnt_ev0 = cnt[IX_EV0];
  assign cnt_ev1 = cnt[IX_EV1];
  assign cnt_cyc = cnt[IX_CYC];

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = ctrl_word;
      RA_CYC:  reg_rdata = cnt_cyc;
      RA_EV0:  reg_rdata = cnt_ev0;
      default: reg_rdata = cnt_ev1;
    endcase
  end

  assign irq = |(ov_flags & ie_bits);
endmodule

// File: rtl/pmu_sva.sv
`timescale 1ns/1ps
module pmu_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        ctrl_run,
  input logic [7:0]  sel0,
  input logic        ev_hit0,
  input logic [2:0]  wrap_vec,
  input logic [2:0]  ov_flags,
  input logic [31:0] cnt_cyc,
  input logic [31:0] cnt_ev0,
  input logic [31:0] cnt_ev1
);
  logic [2:0] clr_req, keep;
  assign clr_req = (reg_we && reg_addr == 2'd0) ? reg_wdata[10:8] : 3'b000;
  assign keep    = ov_flags & ~clr_req;

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != 3'b000) |=> ((ov_flags & $past(wrap_vec)) == $past(wrap_vec))); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrap_vec & clr_req) != 3'b000) |=> ((ov_flags & $past(wrap_vec & clr_req)) != 3'b000)); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != 3'b000) |=> ((ov_flags & $past(keep)) == $past(keep))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !reg_we) |=> ($stable(cnt_cyc) && $stable(cnt_ev0) && $stable(cnt_ev1))); // R7
  AST_EVENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_run && ev_hit0 && !reg_we) |=> (cnt_ev0 == $past(cnt_ev0) + 32'd1)); // R5
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 == 8'hFF && !reg_we) |=> $stable(cnt_ev0)); // R6
endmodule

bind pmu_two_counter pmu_sva u_sva (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ctrl_run(ctrl_run), .sel0(sel0), .ev_hit0(ev_hit[0]), .wrap_vec(wrap_vec),
  .ov_flags(ov_flags), .cnt_cyc(cnt_cyc), .cnt_ev0(cnt_ev0), .cnt_ev1(cnt_ev1)
);

// File: tb/tb_pmu_two_counter.sv
`timescale 1ns/1ps
module tb_pmu_two_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [255:0] ev = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmu_two_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(ev), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called in the low phase; returns in the next low phase
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expect_count(input int s, input int c, input int d, input int n,
                                      input int k, input int j);
    int t;
    t = 0;
    if (s == 255) return 0;
    for (int i = 0; i < 8; i++)
      if ((s == c && i < k) || (s == d && i < j) || s == n) t++;
    return t;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int d, n, k, j;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_check("R1", 2'(a), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 write mask and self-clearing bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R2", 2'd0, 32'h0FFF_F079);
    wr(2'd0, 32'h0);
    rd_check("R2 zero", 2'd0, 32'h0);

    // R10 load and read back, counters idle
    wr(2'd2, 32'h1234_5678);
    wr(2'd3, 32'h0BAD_F00D);
    wr(2'd1, 32'h0000_0070);
    rd_check("R10 ev0", 2'd2, 32'h1234_5678);
    rd_check("R10 ev1", 2'd3, 32'h0BAD_F00D);

    // R7 run off: events do nothing
    wr(2'd0, 32'h0050_7000);
    ev = '1;
    step(5);
    ev = '0;
    rd_check("R7 ev0", 2'd2, 32'h1234_5678);
    rd_check("R7 ev1", 2'd3, 32'h0BAD_F00D);
    rd_check("R7 cyc", 2'd1, 32'h0000_0070);

    // R9 clears
    wr(2'd0, 32'h0000_0002);
    rd_check("R9 ev0", 2'd2, 32'h0);
    rd_check("R9 ev1", 2'd3, 32'h0);
    rd_check("R9 cyc kept", 2'd1, 32'h70);
    wr(2'd0, 32'h0000_0004);
    rd_check("R9 cyc", 2'd1, 32'h0);

    // R5 / R6 sweep of every code on event counter 0
    for (int c = 0; c < 256; c++) begin
      d = (c * 37 + 11) % 256;
      n = (c + 128) % 256;
      k = c % 7 + 1;
      j = (c / 7) % 6 + 1;
      w = 32'h3 | (32'(c) << 12) | (32'(d) << 20);
      wr(2'd0, w);
      for (int i = 0; i < 8; i++) begin
        ev = '0;
        if (i < k) ev[c] = 1'b1;
        if (i < j) ev[d] = 1'b1;
        ev[n] = 1'b1;
        @(negedge clk);
      end
      ev = '0;
      wr(2'd0, w & 32'hFFFF_FFFC);
      rd_check(c == 255 ? "R6" : "R5 ev0", 2'd2, 32'(expect_count(c, c, d, n, k, j)));
      rd_check(d == 255 ? "R6 ev1" : "R5 ev1", 2'd3, 32'(expect_count(d, c, d, n, k, j)));
    end

    // R12 write cycle counts under old run=0
    wr(2'd0, 32'h0FF0_7002);
    ev[7] = 1'b1;
    wr(2'd0, 32'h0FF0_7003);
    @(negedge clk);
    ev = '0;
    wr(2'd0, 32'h0FF0_7000);
    rd_check("R12", 2'd2, 32'd1);

    // R10 load beats increment
    wr(2'd0, 32'h0FF0_7001);
    ev[7] = 1'b1;
    step(2);
    wr(2'd2, 32'd100);
    ev = '0;
    wr(2'd0, 32'h0FF0_7000);
    rd_check("R10 load wins", 2'd2, 32'd100);

    // R8 cycle counter, plain and divided
    wr(2'd0, 32'h0FFF_F005);
    step(40);
    wr(2'd0, 32'h0FFF_F000);
    rd_check("R8 plain", 2'd1, 32'd41);
    wr(2'd0, 32'h0FFF_F00D);
    step(200);
    wr(2'd0, 32'h0FFF_F008);
    rd_check("R8 div64", 2'd1, 32'd3);

    // R3 / R11 event 0 wrap
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, 32'h0FF0_7011);
    ev[7] = 1'b1;
    step(2);
    ev = '0;
    wr(2'd0, 32'h0FF0_7010);
    rd_check("R3 flag set", 2'd0, 32'h0FF0_7110);
    rd_check("R3 wrapped", 2'd2, 32'h0);
    check("R11 irq on", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0FF0_7000);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    rd_check("R3 zero keeps", 2'd0, 32'h0FF0_7100);
    wr(2'd0, 32'h0FF0_7100);
    rd_check("R3 cleared", 2'd0, 32'h0FF0_7000);

    // R3 / R11 cycle wrap
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0FFF_F041);
    wr(2'd0, 32'h0FFF_F040);
    rd_check("R3 cyc flag", 2'd0, 32'h0FFF_F440);
    rd_check("R3 cyc wrapped", 2'd1, 32'h0);
    check("R11 cyc irq", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0700);
    rd_check("R3 all clear", 2'd0, 32'h0);
    check("R11 irq off", {31'b0, irq}, 32'h0);

    // R4 wrap meets clearing write
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 32'h005F_F001);
    ev[5] = 1'b1;
    @(negedge clk);
    ev = '0;
    rd_check("R4 first wrap", 2'd0, 32'h005F_F201);
    wr(2'd3, 32'hFFFF_FFFF);
    ev[5] = 1'b1;
    wr(2'd0, 32'h005F_F201);
    ev = '0;
    wr(2'd0, 32'h005F_F000);
    rd_check("R4 set wins", 2'd0, 32'h005F_F200);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule